// File: doc/BRIEF.md
# Reversible DRAM Cell Access Sequencer

This block steps a behavioural array of transmission-gate DRAM cells through ordered, energy-recovering access sequences. It covers four operations. A write stores a bit. A read copies the inverted bit onto the bit line and captures it in a per-column holding latch. An unwrite returns a stored cell to the neutral level. An unread retracts a previous read by driving the held copy back and then releasing it. Every cell node, the bit line and the column holding latches are three-valued: neutral (mid), logic 0 or logic 1.

A request carries an operation code, a cell address and a data bit. For unwrite and unread the data bit is the caller's copy of the stored value. A request is offered on a valid/ready handshake. `req_ready` is high exactly when no sequence is running, and a request is taken on a clock edge where `req_valid` and `req_ready` are both high. While a sequence runs, `req_ready` is low and anything presented is ignored, so the requester holds or re-presents the request until it is accepted. The sequencer then performs one sub-operation per clock, shows the cell gate, bit-line level and inverter-rail split state on its pins, and pulses `done` once the last step has settled. The block does not check the adiabatic rules or the caller's copy to refuse an access. It flags breaches of these rules alongside `done`.

Top module: `revdram_sequencer`

## Requirements
- R1: After reset, busy, done, rsp_data, rule_viol, copy_err, cell_gate and rail_split are 0, bl_lvl is mid, req_ready is 1 and every cell and column latch holds mid. The level encodings are mid=2'b00, logic 0=2'b01 and logic 1=2'b10.
- R2: A request is taken only on an edge with req_valid and req_ready both high, and req_ready equals not busy. Busy rises in the cycle after acceptance and stays high until the last step. Done is a one-cycle pulse in the cycle after the last step, with busy low. Requests presented while busy are ignored. The operation codes are write=0, read=1, unwrite=2 and unread=3.
- R3: Write takes four steps, each shown in the cycle after its edge. In order: the cell gate turns on with the bit line at mid, the bit line goes to the data level with the node following, the gate turns off, and the bit line returns to mid.
- R4: Unwrite performs the write steps in reverse. In order: the bit line goes to the copy level, the gate turns on, the bit line returns to mid with the node following it to mid, and the gate turns off.
- R5: Read takes five steps. In order: the rails split, the bit line takes the inverse of the node, the column latch captures the bit line, the rails merge, and the bit line returns to mid. rsp_data is 1 after a read exactly when the cell held logic 1.
- R6: Unread performs the read steps in reverse. In order: the bit line is driven from the column latch, the rails split, the column latch is cleared to mid, the bit line returns to mid, and the rails merge.
- R7: rule_viol is high in the done cycle exactly when, during that access, the cell gate was turned on while the bit-line level differed from the node level.
- R8: copy_err is high in the done cycle of an unwrite or unread exactly when the supplied copy's level differs from the addressed cell's level at the start of the sequence. It is never high for write or read.
- R9: Whenever busy is low, bl_lvl is mid and cell_gate and rail_split are 0.
- R10: An access changes only the addressed cell and the addressed column latch, so other cells keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_op | input | 2 | Operation: 0 write, 1 read, 2 unwrite, 3 unread |
| req_row | input | RW | Cell row |
| req_col | input | CW | Cell column |
| req_data | input | 1 | Write data, or the caller's copy for unwrite/unread |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| rsp_data | output | 1 | Data returned by the last read |
| rule_viol | output | 1 | Gate opened across a level mismatch (valid with done) |
| copy_err | output | 1 | Supplied copy disagreed with the cell (valid with done) |
| bl_lvl | output | 2 | Active bit-line level |
| cell_gate | output | 1 | Addressed cell's transmission gate on |
| rail_split | output | 1 | Addressed cell's inverter rails split |

## Verification
The completion pulse of one access and the acceptance of the next fall in the same cycle, because `req_ready` is already high while `done` is shown. The bench provokes this by presenting each new request on the done cycle of the previous one, and a cycle-accurate behavioural model checks that the new sequence starts exactly one edge later with idle levels in between. A second overlap is a request offered while a sequence is running. The bench raises `req_valid` with a different operation during the middle steps, and the model checks that the running sequence is unchanged and that nothing further is accepted afterwards.

// File: rtl/revdram_pkg.sv
package revdram_pkg;

  typedef enum logic [1:0] {
    LV_MID  = 2'b00,
    LV_ZERO = 2'b01,
    LV_ONE  = 2'b10
  } lvl_t;

  typedef enum logic [1:0] {
    OP_WRITE   = 2'd0,
    OP_READ    = 2'd1,
    OP_UNWRITE = 2'd2,
    OP_UNREAD  = 2'd3
  } op_t;

  typedef enum logic [3:0] {
    ACT_NONE,
    ACT_GATE_ON,
    ACT_GATE_OFF,
    ACT_BL_DATA,
    ACT_BL_MID,
    ACT_BL_INV,
    ACT_BL_COPY,
    ACT_COL_LATCH,
    ACT_COL_CLEAR,
    ACT_SPLIT_ON,
    ACT_SPLIT_OFF
  } act_t;

  localparam int STEP_W = 3;

  function automatic lvl_t lv_of(input logic b);
    return b ? LV_ONE : LV_ZERO;
  endfunction

  function automatic lvl_t lv_inv(input lvl_t l);
    case (l)
      LV_ONE:  return LV_ZERO;
      LV_ZERO: return LV_ONE;
      default: return LV_MID;
    endcase
  endfunction

  function automatic logic [STEP_W-1:0] op_len(input op_t op);
    return (op == OP_WRITE || op == OP_UNWRITE) ? STEP_W'(4) : STEP_W'(5);
  endfunction

  // Ordered sub-operations; the un* variants are the exact reversals.
  function automatic act_t act_of(input op_t op, input logic [STEP_W-1:0] s);
    act_t a;
    a = ACT_NONE;
    case (op)
      OP_WRITE: case (s)
        3'd1: a = ACT_GATE_ON;
        3'd2: a = ACT_BL_DATA;
        3'd3: a = ACT_GATE_OFF;
        3'd4: a = ACT_BL_MID;
        default: a = ACT_NONE;
      endcase
      OP_UNWRITE: case (s)
        3'd1: a = ACT_BL_DATA;
        3'd2: a = ACT_GATE_ON;
        3'd3: a = ACT_BL_MID;
        3'd4: a = ACT_GATE_OFF;
        default: a = ACT_NONE;
      endcase
      OP_READ: case (s)
        3'd1: a = ACT_SPLIT_ON;
        3'd2: a = ACT_BL_INV;
        3'd3: a = ACT_COL_LATCH;
        3'd4: a = ACT_SPLIT_OFF;
        3'd5: a = ACT_BL_MID;
        default: a = ACT_NONE;
      endcase
      default: case (s)
        3'd1: a = ACT_BL_COPY;
        3'd2: a = ACT_SPLIT_ON;
        3'd3: a = ACT_COL_CLEAR;
        3'd4: a = ACT_BL_MID;
        3'd5: a = ACT_SPLIT_OFF;
        default: a = ACT_NONE;
      endcase
    endcase
    return a;
  endfunction

endpackage

// File: rtl/revdram_step_ctl.sv
module revdram_step_ctl
  import revdram_pkg::*;
#(
  parameter int RW = 2,
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [1:0]    req_op,
  input  logic [RW-1:0] req_row,
  input  logic [CW-1:0] req_col,
  input  logic          req_data,
  output logic          req_ready,
  output logic          busy,
  output logic          done,
  output logic          start,
  output logic          chk_copy,
  output act_t          act,
  output logic [RW-1:0] row_q,
  output logic [CW-1:0] col_q,
  output logic          data_q
);

  op_t               op_q;
  logic [STEP_W-1:0] step_q;

  assign busy      = (step_q != '0);
  assign req_ready = !busy;
  assign start     = req_valid && req_ready;
  assign act       = busy ? act_of(op_q, step_q) : ACT_NONE;
  assign chk_copy  = (step_q == STEP_W'(1)) &&
                     (op_q == OP_UNWRITE || op_q == OP_UNREAD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q <= '0;
      done   <= 1'b0;
      op_q   <= OP_WRITE;
      row_q  <= '0;
      col_q  <= '0;
      data_q <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (req_valid) begin
          op_q   <= op_t'(req_op);
          row_q  <= req_row;
          col_q  <= req_col;
          data_q <= req_data;
          step_q <= STEP_W'(1);
        end
      end else if (step_q == op_len(op_q)) begin
        step_q <= '0;
        done   <= 1'b1;
      end else begin
        step_q <= step_q + STEP_W'(1);
      end
    end
  end

  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_not_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_ignore_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_valid) |=> ($stable(op_q) && $stable(row_q) && $stable(col_q)));
  assert_end_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

endmodule

// File: rtl/revdram_cell_array.sv
module revdram_cell_array
  import revdram_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CW = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic          start,
  input  logic          chk_copy,
  input  act_t          act,
  input  logic [RW-1:0] row,
  input  logic [CW-1:0] col,
  input  logic          data,
  output lvl_t          bl_q,
  output logic          gate_q,
  output logic          split_q,
  output logic          rsp_q,
  output logic          viol_q,
  output logic          cerr_q
);

  lvl_t cell_q [ROWS][COLS];
  lvl_t hold_q [COLS];
  lvl_t node;

  assign node = cell_q[row][col];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++)
        for (int c = 0; c < COLS; c++)
          cell_q[r][c] <= LV_MID;
      for (int c = 0; c < COLS; c++)
        hold_q[c] <= LV_MID;
      bl_q    <= LV_MID;
      gate_q  <= 1'b0;
      split_q <= 1'b0;
      rsp_q   <= 1'b0;
      viol_q  <= 1'b0;
      cerr_q  <= 1'b0;
    end else begin
      if (start) begin
        viol_q <= 1'b0;
        cerr_q <= 1'b0;
      end
      if (chk_copy && lv_of(data) != node)
        cerr_q <= 1'b1;
      case (act)
        ACT_GATE_ON: begin
          gate_q <= 1'b1;
          if (bl_q != node) viol_q <= 1'b1;
        end
        ACT_GATE_OFF: gate_q <= 1'b0;
        ACT_BL_DATA: begin
          bl_q <= lv_of(data);
          if (gate_q) cell_q[row][col] <= lv_of(data);
        end
        ACT_BL_MID: begin
          bl_q <= LV_MID;
          if (gate_q) cell_q[row][col] <= LV_MID;
        end
        ACT_BL_INV:    bl_q <= lv_inv(node);
        ACT_BL_COPY:   bl_q <= hold_q[col];
        ACT_COL_LATCH: begin
          hold_q[col] <= bl_q;
          rsp_q       <= (bl_q == LV_ZERO);
        end
        ACT_COL_CLEAR: hold_q[col] <= LV_MID;
        ACT_SPLIT_ON:  split_q <= 1'b1;
        ACT_SPLIT_OFF: split_q <= 1'b0;
        default: ;
      endcase
    end
  end

  assert_idle_mid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (bl_q == LV_MID && !gate_q && !split_q));
  assert_gate_split_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_q && split_q));
  assert_mismatch_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_GATE_ON && bl_q != node) |=> viol_q);
  assert_copy_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_copy && lv_of(data) != node) |=> cerr_q);

endmodule

// File: rtl/revdram_sequencer.sv
module revdram_sequencer
  import revdram_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CW = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [RW-1:0] req_row,
  input  logic [CW-1:0] req_col,
  input  logic          req_data,
  output logic          busy,
  output logic          done,
  output logic          rsp_data,
  output logic          rule_viol,
  output logic          copy_err,
  output logic [1:0]    bl_lvl,
  output logic          cell_gate,
  output logic          rail_split
);

  logic          start, chk_copy, data_q, viol_q, cerr_q;
  act_t          act;
  logic [RW-1:0] row_q;
  logic [CW-1:0] col_q;
  lvl_t          bl_q;

  revdram_step_ctl #(.RW(RW), .CW(CW)) u_ctl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_op(req_op), .req_row(req_row),
    .req_col(req_col), .req_data(req_data),
    .req_ready(req_ready), .busy(busy), .done(done), .start(start),
    .chk_copy(chk_copy), .act(act),
    .row_q(row_q), .col_q(col_q), .data_q(data_q)
  );

  revdram_cell_array #(.ROWS(ROWS), .COLS(COLS)) u_arr (
    .clk(clk), .rst_n(rst_n), .active(busy), .start(start),
    .chk_copy(chk_copy), .act(act), .row(row_q), .col(col_q),
    .data(data_q), .bl_q(bl_q), .gate_q(cell_gate), .split_q(rail_split),
    .rsp_q(rsp_data), .viol_q(viol_q), .cerr_q(cerr_q)
  );

  assign bl_lvl    = bl_q;
  assign rule_viol = done && viol_q;
  assign copy_err  = done && cerr_q;

endmodule

// File: tb/tb_revdram_sequencer.sv
module tb_revdram_sequencer;

  localparam int ROWS = 4;
  localparam int COLS = 4;
  localparam int MID = 0, ZER = 1, ONE = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_op = 2'd0;
  logic [1:0] req_row = '0;
  logic [1:0] req_col = '0;
  logic req_data = 1'b0;
  logic req_ready, busy, done, rsp_data, rule_viol, copy_err;
  logic [1:0] bl_lvl;
  logic cell_gate, rail_split;

  int total = 0, bad = 0;
  int m_cell [ROWS][COLS];
  int m_hold [COLS];
  int m_bl, m_gate, m_split, m_rsp, m_viol, m_cerr;

  always #2.5 clk = ~clk;

  revdram_sequencer #(.ROWS(ROWS), .COLS(COLS)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_row(req_row), .req_col(req_col), .req_data(req_data),
    .busy(busy), .done(done), .rsp_data(rsp_data), .rule_viol(rule_viol),
    .copy_err(copy_err), .bl_lvl(bl_lvl), .cell_gate(cell_gate),
    .rail_split(rail_split)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int lv(input bit b);
    return b ? ONE : ZER;
  endfunction

  function automatic int inv(input int l);
    return (l == ONE) ? ZER : (l == ZER) ? ONE : MID;
  endfunction

  task automatic cmp_drives(input string tag);
    chk(int'(bl_lvl) == m_bl, tag, "bit line", int'(bl_lvl), m_bl);
    chk(int'(cell_gate) == m_gate, tag, "cell gate", int'(cell_gate), m_gate);
    chk(int'(rail_split) == m_split, tag, "rail split", int'(rail_split), m_split);
  endtask

  // Behavioural model of one step s of operation op on cell (r,c).
  task automatic model_step(input int op, input int s, input int r, input int c,
                            input bit d);
    case (op)
      0: case (s)
        1: begin if (m_bl != m_cell[r][c]) m_viol = 1; m_gate = 1; end
        2: begin m_bl = lv(d); m_cell[r][c] = lv(d); end
        3: m_gate = 0;
        default: m_bl = MID;
      endcase
      2: case (s)
        1: begin if (lv(d) != m_cell[r][c]) m_cerr = 1; m_bl = lv(d); end
        2: begin if (m_bl != m_cell[r][c]) m_viol = 1; m_gate = 1; end
        3: begin m_bl = MID; m_cell[r][c] = MID; end
        default: m_gate = 0;
      endcase
      1: case (s)
        1: m_split = 1;
        2: m_bl = inv(m_cell[r][c]);
        3: begin m_hold[c] = m_bl; m_rsp = (m_bl == ZER) ? 1 : 0; end
        4: m_split = 0;
        default: m_bl = MID;
      endcase
      default: case (s)
        1: begin if (lv(d) != m_cell[r][c]) m_cerr = 1; m_bl = m_hold[c]; end
        2: m_split = 1;
        3: m_hold[c] = MID;
        4: m_bl = MID;
        default: m_split = 0;
      endcase
    endcase
  endtask

  // Called at a negedge with the bench idle; returns at the done negedge.
  task automatic run_op(input int op, input int r, input int c, input bit d,
                        input bit spurious);
    string tag;
    int n;
    tag = (op == 0) ? "R3" : (op == 1) ? "R5" : (op == 2) ? "R4" : "R6";
    n = (op == 0 || op == 2) ? 4 : 5;
    m_viol = 0; m_cerr = 0;
    req_valid = 1'b1; req_op = 2'(op); req_row = 2'(r); req_col = 2'(c);
    req_data = d;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1 && done == 1'b0, "R2", "busy after accept", int'(busy), 1);
    chk(req_ready == 1'b0, "R2", "ready while busy", int'(req_ready), 0);
    cmp_drives(tag);
    for (int s = 1; s <= n; s++) begin
      if (spurious && s < n) begin
        req_valid = 1'b1; req_op = 2'(1); req_row = 2'(r ^ 1); req_data = ~d;
      end else begin
        req_valid = 1'b0;
      end
      @(negedge clk);
      model_step(op, s, r, c, d);
      cmp_drives(tag);
      chk(int'(busy) == ((s < n) ? 1 : 0), "R2", "busy", int'(busy), (s < n) ? 1 : 0);
      chk(int'(done) == ((s == n) ? 1 : 0), "R2", "done", int'(done), (s == n) ? 1 : 0);
    end
    req_valid = 1'b0;
    chk(int'(rule_viol) == m_viol, "R7", "rule violation", int'(rule_viol), m_viol);
    chk(int'(copy_err) == m_cerr, "R8", "copy error", int'(copy_err), m_cerr);
    chk(bl_lvl == 2'b00 && !cell_gate && !rail_split, "R9", "idle levels at done",
        int'(bl_lvl), 0);
    chk(req_ready == 1'b1, "R2", "ready with done", int'(req_ready), 1);
    if (op == 1)
      chk(int'(rsp_data) == m_rsp, "R5", "read data", int'(rsp_data), m_rsp);
  endtask

  initial begin
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) m_cell[r][c] = MID;
    for (int c = 0; c < COLS; c++) m_hold[c] = MID;
    m_bl = MID; m_gate = 0; m_split = 0; m_rsp = 0; m_viol = 0; m_cerr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && req_ready, "R1", "control after reset", int'(busy), 0);
    chk(bl_lvl == 2'b00 && !cell_gate && !rail_split, "R1", "drives after reset",
        int'(bl_lvl), 0);
    chk(!rsp_data && !rule_viol && !copy_err, "R1", "flags after reset",
        int'(rsp_data), 0);

    // Full forward and reverse round trip on one cell.
    run_op(0, 1, 2, 1'b1, 1'b0);
    chk(bl_lvl == 2'b00, "R3", "bit line back at mid encoding", int'(bl_lvl), 0);
    run_op(1, 1, 2, 1'b0, 1'b0);
    chk(rsp_data == 1'b1, "R5", "read returns 1", int'(rsp_data), 1);
    run_op(3, 1, 2, 1'b1, 1'b0);
    run_op(2, 1, 2, 1'b1, 1'b0);
    chk(rule_viol == 1'b0, "R4", "clean unwrite", int'(rule_viol), 0);
    run_op(0, 1, 2, 1'b0, 1'b0);
    chk(rule_viol == 1'b0, "R4", "cell returned to mid allows clean write",
        int'(rule_viol), 0);

    // Independence of cells.
    run_op(0, 0, 0, 1'b0, 1'b0);
    run_op(0, 3, 1, 1'b1, 1'b0);
    run_op(1, 0, 0, 1'b0, 1'b0);
    chk(rsp_data == 1'b0, "R10", "cell (0,0) keeps 0", int'(rsp_data), 0);
    run_op(1, 3, 1, 1'b0, 1'b0);
    chk(rsp_data == 1'b1, "R10", "cell (3,1) keeps 1", int'(rsp_data), 1);

    // Gate opened across a mismatch: write onto an occupied cell.
    run_op(0, 3, 1, 1'b0, 1'b0);
    chk(rule_viol == 1'b1, "R7", "write over data flagged", int'(rule_viol), 1);
    // Wrong copy on unwrite and on unread.
    run_op(2, 3, 1, 1'b1, 1'b0);
    chk(copy_err == 1'b1, "R8", "unwrite wrong copy", int'(copy_err), 1);
    run_op(0, 2, 2, 1'b1, 1'b0);
    run_op(1, 2, 2, 1'b0, 1'b0);
    run_op(3, 2, 2, 1'b0, 1'b0);
    chk(copy_err == 1'b1 && rule_viol == 1'b0, "R8", "unread wrong copy",
        int'(copy_err), 1);

    // Requests offered while busy must be ignored.
    run_op(0, 0, 3, 1'b1, 1'b1);
    @(negedge clk);
    chk(busy == 1'b0, "R2", "no request taken while busy", int'(busy), 0);
    cmp_drives("R9");

    // Random back-to-back traffic.
    for (int i = 0; i < 300; i++) begin
      int op, r, c;
      bit d;
      op = int'($urandom_range(0, 3));
      r  = int'($urandom_range(0, ROWS - 1));
      c  = int'($urandom_range(0, COLS - 1));
      d  = 1'($urandom_range(0, 1));
      if (op >= 2 && $urandom_range(0, 3) != 0) d = (m_cell[r][c] == ONE);
      run_op(op, r, c, d, 1'($urandom_range(0, 7) == 0));
    end
    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    bad++;
    total++;
    $display("FAIL R2 watchdog: actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule